// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is a register-programmed SPI master built for serial NOR flash. Software loads up to four bytes into a transmit register and writes a second control register. That write chooses one of four chip selects, the number of bytes to send and the number of bytes to read back. The controller then clocks the bytes out, collects the reply bytes and raises a sticky finished flag. Two further trigger bits in the same control register run fixed sequences without any transmit setup: a flash status read, whose reply byte appears in the controller's own status register, and a write-enable opcode.

The bus is a simple 32-bit register port with combinational reads and single-cycle writes. The serial side runs in clock mode 3. SCK rests high, the controller moves MOSI on falling edges and samples MISO on rising edges. Each SCK half period lasts `HALF_DIV` system clocks. The first control register only stores the software-mode and write-burst mode bits; no mapped access is built here.

Top module: `spi_nor_cmdctl`

## Requirements
- R1: After reset every register reads 0, all chip selects are high, SCK is high and MOSI is high.
- R2: Each bit uses a low SCK phase of HALF_DIV clocks followed by a high phase of HALF_DIV clocks. MOSI changes only while SCK is low or idle. The number of rising edges equals 8 times the total byte count.
- R3: Transmit bytes go out lowest byte of the transmit register (0x0C) first, each byte MSB first. During receive bytes MOSI is held at 1. A transmit count field (control2 bits [2:0]) of 0 means 1 byte, and a value above 4 means 4 bytes.
- R4: Receive bytes are sampled MSB first and stored with the first byte in receive register (0x10) bits [7:0]. Byte lanes that were not received read 0. A receive count (control2 bits [6:4]) above 4 means 4 bytes. The receive register is rewritten only by transfers started with control2 bit 7.
- R5: Only the chip select numbered by control2 bits [13:12] goes low. It goes low on the clock edge after the starting write. It stays low for (2N+2)·HALF_DIV clocks, where N is the bit count. The finished flag (status bit 8) reads 1 from (2N+4)·HALF_DIV+2 edges after the starting write, when every chip select is already high.
- R6: Setting control2 bit 10 sends opcode 0x05, reads one byte and places it in status bits [7:0], where bit 0 is write-in-progress and bit 1 is the write-enable latch. The receive register is left unchanged.
- R7: Setting control2 bit 11 sends only the opcode 0x06 (8 bits). The receive register and status bits [7:0] are left unchanged.
- R8: When more than one trigger bit is set in one write, bit 10 wins over bit 11, which wins over bit 7.
- R9: The finished flag is set at completion. Writing status with bit 8 = 0 clears it, and writing bit 8 = 1 leaves it alone. If a clear lands in the cycle of completion, the flag ends up set.
- R10: A control2 write made while a sequence is pending or running is ignored: its fields are not stored and no sequence starts.
- R11: Control1 (0x00) keeps only bit 28 (software mode) and bit 29 (write-burst mode); its other bits read 0. Control2 (0x04) reads back bits [2:0], [6:4] and [13:12], and its trigger bits read 0. A control2 write with no trigger bit starts nothing.
- R12: The registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10. The status register is at 0x08, and only its bits [8:0] can be nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two events can land on the same clock edge: completion of a sequence, which sets the finished flag, and a software write of zero to status bit 8, which clears it. The bench computes the edge at which the flag sets from the bit count and places the clearing write exactly on that edge. It then expects the flag to read 1. A second overlap is a control2 write issued in the middle of a transfer, which is judged by the unchanged control2 readback and by the absence of any extra chip-select activity afterwards.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
   localparam int MAX_BYTES = 4;
   localparam int BITS_W    = $clog2(8 * 2 * MAX_BYTES + 1);

   localparam logic [7:0] OFS_CTRL1  = 8'h00;
   localparam logic [7:0] OFS_CTRL2  = 8'h04;
   localparam logic [7:0] OFS_STATUS = 8'h08;
   localparam logic [7:0] OFS_TXD    = 8'h0C;
   localparam logic [7:0] OFS_RXD    = 8'h10;

   localparam int BIT_SWMODE = 28;
   localparam int BIT_WBMODE = 29;
   localparam int BIT_GO     = 7;
   localparam int BIT_STSRD  = 10;
   localparam int BIT_WREN   = 11;
   localparam int BIT_DONE   = 8;
   localparam int TXN_LSB    = 0;
   localparam int RXN_LSB    = 4;
   localparam int SEL_LSB    = 12;

   localparam logic [7:0] OPC_STSRD = 8'h05;
   localparam logic [7:0] OPC_WREN  = 8'h06;

   typedef enum logic [1:0] {K_USER, K_STSRD, K_WREN} seq_kind_t;
   typedef enum logic [2:0] {E_IDLE, E_LEAD, E_LOW, E_HIGH, E_TRAIL, E_GAP} eng_st_t;

   function automatic logic [2:0] fit_tx(input logic [2:0] v);
      if (v == 3'd0) return 3'd1;
      if (v > 3'd4) return 3'd4;
      return v;
   endfunction

   function automatic logic [2:0] fit_rx(input logic [2:0] v);
      if (v > 3'd4) return 3'd4;
      return v;
   endfunction
endpackage

// File: rtl/spi_nor_tick.sv
module spi_nor_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   if (HALF_DIV == 1) begin : g_fast
      assign tick = 1'b1;
      wire unused_tick_in = &{clr, clk, rst_n};
   end else begin : g_div
      logic [CNT_W-1:0] cnt;
      assign tick = (cnt == CNT_W'(HALF_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (clr || tick) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spi_nor_engine.sv
module spi_nor_engine import spi_nor_pkg::*; #(
   parameter int HALF_DIV = 2,
   parameter int NUM_CS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [31:0]       tx_word,
   input  logic [2:0]        tx_n,
   input  logic [2:0]        rx_n,
   input  logic [1:0]        sel,
   input  logic              spi_miso,
   output logic              spi_sck,
   output logic              spi_mosi,
   output logic [NUM_CS-1:0] spi_cs_n,
   output logic              busy,
   output logic              done,
   output logic [31:0]       rx_word
);
   eng_st_t           st;
   logic              tick;
   logic [31:0]       sh;
   logic [31:0]       rx_sh;
   logic [31:0]       sh_load;
   logic [BITS_W-1:0] left;
   logic [2:0]        rxn_q;
   logic              gap2;
   logic [NUM_CS-1:0] sel_n;

   spi_nor_tick #(.HALF_DIV(HALF_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .clr(st == E_IDLE), .tick(tick)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
      assign sel_n[g] = (sel != 2'(g));
   end

   always_comb begin
      for (int i = 0; i < MAX_BYTES; i++)
         sh_load[31-8*i -: 8] = (i < int'(tx_n)) ? tx_word[8*i +: 8] : 8'hFF;
   end

   always_comb begin
      rx_word = '0;
      for (int i = 0; i < MAX_BYTES; i++)
         if (i < int'(rxn_q)) rx_word[8*i +: 8] = rx_sh[8*(int'(rxn_q)-1-i) +: 8];
   end

   assign busy = (st != E_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         spi_sck  <= 1'b1;
         spi_mosi <= 1'b1;
         spi_cs_n <= '1;
         sh       <= '1;
         rx_sh    <= '0;
         left     <= '0;
         rxn_q    <= '0;
         gap2     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            E_IDLE: if (go) begin
               st       <= E_LEAD;
               spi_cs_n <= sel_n;
               sh       <= sh_load;
               left     <= BITS_W'({tx_n, 3'b000}) + BITS_W'({rx_n, 3'b000});
               rxn_q    <= rx_n;
            end
            E_LEAD: if (tick) begin
               st       <= E_LOW;
               spi_sck  <= 1'b0;
               spi_mosi <= sh[31];
               sh       <= {sh[30:0], 1'b1};
            end
            E_LOW: if (tick) begin
               st      <= E_HIGH;
               spi_sck <= 1'b1;
               rx_sh   <= {rx_sh[30:0], spi_miso};
            end
            E_HIGH: if (tick) begin
               left <= left - 1'b1;
               if (left == BITS_W'(1)) begin
                  st <= E_TRAIL;
               end else begin
                  st       <= E_LOW;
                  spi_sck  <= 1'b0;
                  spi_mosi <= sh[31];
                  sh       <= {sh[30:0], 1'b1};
               end
            end
            E_TRAIL: if (tick) begin
               st       <= E_GAP;
               spi_cs_n <= '1;
               spi_mosi <= 1'b1;
               gap2     <= 1'b0;
            end
            E_GAP: if (tick) begin
               if (gap2) begin
                  st   <= E_IDLE;
                  done <= 1'b1;
               end else begin
                  gap2 <= 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_nor_regs.sv
module spi_nor_regs import spi_nor_pkg::*; #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [31:0]       eng_rx,
   output logic              start_q,
   output logic [31:0]       l_tx_word,
   output logic [2:0]        l_tx_n,
   output logic [2:0]        l_rx_n,
   output logic [1:0]        l_sel,
   output logic              done_flag
);
   logic [1:0]  mode_q;
   logic [2:0]  txf_q, rxf_q;
   logic [1:0]  sel_q;
   logic [31:0] txd_q, rxd_q;
   logic [7:0]  fsts_q;
   seq_kind_t   kind_q;

   wire at_c1  = (bus_addr == ADDR_W'(OFS_CTRL1));
   wire at_c2  = (bus_addr == ADDR_W'(OFS_CTRL2));
   wire at_st  = (bus_addr == ADDR_W'(OFS_STATUS));
   wire at_tx  = (bus_addr == ADDR_W'(OFS_TXD));
   wire at_rx  = (bus_addr == ADDR_W'(OFS_RXD));
   wire busy   = start_q | eng_busy | eng_done;
   wire trig   = bus_wdata[BIT_GO] | bus_wdata[BIT_STSRD] | bus_wdata[BIT_WREN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         txf_q     <= '0;
         rxf_q     <= '0;
         sel_q     <= '0;
         txd_q     <= '0;
         rxd_q     <= '0;
         fsts_q    <= '0;
         kind_q    <= K_USER;
         start_q   <= 1'b0;
         done_flag <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (bus_we && at_c1) mode_q <= {bus_wdata[BIT_WBMODE], bus_wdata[BIT_SWMODE]};
         if (bus_we && at_tx) txd_q <= bus_wdata;
         if (bus_we && at_c2 && !busy) begin
            txf_q <= bus_wdata[TXN_LSB +: 3];
            rxf_q <= bus_wdata[RXN_LSB +: 3];
            sel_q <= bus_wdata[SEL_LSB +: 2];
            if (trig) begin
               start_q <= 1'b1;
               if (bus_wdata[BIT_STSRD])     kind_q <= K_STSRD;
               else if (bus_wdata[BIT_WREN]) kind_q <= K_WREN;
               else                          kind_q <= K_USER;
            end
         end
         if (eng_done) begin
            done_flag <= 1'b1;
            if (kind_q == K_STSRD) fsts_q <= eng_rx[7:0];
            if (kind_q == K_USER)  rxd_q  <= eng_rx;
         end else if (bus_we && at_st && !bus_wdata[BIT_DONE]) begin
            done_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      l_sel = sel_q;
      case (kind_q)
         K_STSRD: begin l_tx_word = {24'h0, OPC_STSRD}; l_tx_n = 3'd1; l_rx_n = 3'd1; end
         K_WREN:  begin l_tx_word = {24'h0, OPC_WREN};  l_tx_n = 3'd1; l_rx_n = 3'd0; end
         default: begin l_tx_word = txd_q; l_tx_n = fit_tx(txf_q); l_rx_n = fit_rx(rxf_q); end
      endcase
   end

   always_comb begin
      bus_rdata = '0;
      if (at_c1) begin
         bus_rdata[BIT_SWMODE] = mode_q[0];
         bus_rdata[BIT_WBMODE] = mode_q[1];
      end else if (at_c2) begin
         bus_rdata[TXN_LSB +: 3] = txf_q;
         bus_rdata[RXN_LSB +: 3] = rxf_q;
         bus_rdata[SEL_LSB +: 2] = sel_q;
      end else if (at_st) begin
         bus_rdata[7:0]      = fsts_q;
         bus_rdata[BIT_DONE] = done_flag;
      end else if (at_tx) begin
         bus_rdata = txd_q;
      end else if (at_rx) begin
         bus_rdata = rxd_q;
      end
   end
endmodule

// File: rtl/spi_nor_cmdctl.sv
module spi_nor_cmdctl import spi_nor_pkg::*; #(
   parameter int HALF_DIV = 2,
   parameter int NUM_CS   = 4,
   parameter int ADDR_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   output logic [NUM_CS-1:0] spi_cs_n,
   input  logic              spi_miso
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("NUM_CS must lie in 1..4");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end

   logic        start_q, eng_busy, eng_done, done_flag;
   logic [31:0] l_tx_word, eng_rx;
   logic [2:0]  l_tx_n, l_rx_n;
   logic [1:0]  l_sel;

   spi_nor_regs #(.ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
      .start_q(start_q), .l_tx_word(l_tx_word), .l_tx_n(l_tx_n), .l_rx_n(l_rx_n),
      .l_sel(l_sel), .done_flag(done_flag)
   );

   spi_nor_engine #(.HALF_DIV(HALF_DIV), .NUM_CS(NUM_CS)) i_engine (
      .clk(clk), .rst_n(rst_n), .go(start_q),
      .tx_word(l_tx_word), .tx_n(l_tx_n), .rx_n(l_rx_n), .sel(l_sel),
      .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
      .busy(eng_busy), .done(eng_done), .rx_word(eng_rx)
   );
endmodule

// File: rtl/spi_nor_cmdctl_chk.sv
module spi_nor_cmdctl_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs_n,
   input logic              done_flag,
   input logic              clr_wr
);
   // R5: at most one chip select low
   a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~spi_cs_n) <= 1);

   // R2: clock rests high whenever nothing is selected
   a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (&spi_cs_n) |-> spi_sck);

   // R2: data never moves at a rising clock edge
   a_r2_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $stable(spi_mosi));

   // R5: select changes only while the clock is high
   a_r5_cs_moves_high: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n != $past(spi_cs_n)) |-> (spi_sck && $past(spi_sck)));

   // R5: finished flag rises only after release
   a_r5_flag_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> (&spi_cs_n));

   // R9: flag falls only through a clearing write
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_flag) |-> $past(clr_wr));
endmodule

bind spi_nor_cmdctl spi_nor_cmdctl_chk #(.NUM_CS(NUM_CS)) i_chk (
   .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
   .spi_cs_n(spi_cs_n), .done_flag(done_flag),
   .clr_wr(bus_we && (bus_addr == ADDR_W'(8'h08)) && !bus_wdata[8])
);

// File: tb/test_spi_nor_cmdctl.sv
module test_spi_nor_cmdctl;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 2;
   localparam logic [4:0] A_C1 = 5'h00, A_C2 = 5'h04, A_ST = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_miso = 1'b1;
   logic [3:0]  spi_cs_n;

   spi_nor_cmdctl #(.HALF_DIV(HALF), .NUM_CS(4), .ADDR_W(5)) i_spi_nor_cmdctl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit reported = 0;

   // flash-side model
   logic [63:0] slv_stream = '0;
   logic [63:0] mosi_q = '0;
   int fall_cnt = 0, rise_cnt = 0;
   wire cs_any = ~&spi_cs_n;

   always @(negedge spi_sck) if (cs_any === 1'b1) begin
      if (fall_cnt < 64) spi_miso = slv_stream[63-fall_cnt];
      fall_cnt++;
   end
   always @(posedge spi_sck) if (cs_any === 1'b1) begin
      mosi_q = {mosi_q[62:0], spi_mosi};
      rise_cnt++;
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      end
      $finish;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic set_reply(input int txb, input logic [31:0] bytes, input int nb);
      slv_stream = '0;
      for (int i = 0; i < nb; i++) slv_stream[63-8*txb-8*i -: 8] = bytes[8*i +: 8];
   endtask

   // Reference timeline, compared each clock: select, clock and finished flag
   task automatic xfer(input logic [31:0] c2, input int bank, input int nbits,
                       input int inj_t, input logic [4:0] inj_a, input logic [31:0] inj_d,
                       input string tag);
      int mism = 0;
      int t_flag = 2 + (2*nbits + 4)*HALF;
      fall_cnt = 0; rise_cnt = 0; mosi_q = '0;
      wr(A_C2, c2);
      bus_addr = A_ST;
      for (int t = 1; t <= t_flag + 1; t++) begin
         logic [3:0] e_cs;
         logic e_sck, e_flag;
         int u;
         @(negedge clk);
         if (t == inj_t) begin bus_we = 1'b1; bus_addr = inj_a; bus_wdata = inj_d; end
         else if (t == inj_t + 1) begin bus_we = 1'b0; bus_addr = A_ST; end
         #1;
         e_cs = (t <= (2*nbits + 2)*HALF) ? ~(4'b1 << bank) : 4'hF;
         u = t - 1 - HALF;
         e_sck = !(u >= 0 && u < 2*nbits*HALF && (u % (2*HALF)) < HALF);
         e_flag = (t >= t_flag);
         if (spi_cs_n !== e_cs) mism++;
         if (spi_sck !== e_sck) mism++;
         if (t != inj_t && bus_rdata[8] !== e_flag) mism++;
      end
      check(mism == 0, {tag, " R5 timeline mismatches"}, mism, 0);
      check(rise_cnt == nbits, {tag, " R2 rising edges"}, rise_cnt, nbits);
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [63:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_C1, d); check(d == 0, "R1 ctrl1 reset", d, 0);
      rd(A_C2, d); check(d == 0, "R1 ctrl2 reset", d, 0);
      rd(A_ST, d); check(d == 0, "R1 status reset", d, 0);
      rd(A_TX, d); check(d == 0, "R1 tx reset", d, 0);
      rd(A_RX, d); check(d == 0, "R1 rx reset", d, 0);
      check(spi_cs_n == 4'hF && spi_sck && spi_mosi, "R1 pins idle", {spi_cs_n, spi_sck, spi_mosi}, 6'h3F);

      // R11 R12 register holding
      wr(A_C1, 32'hFFFF_FFFF); rd(A_C1, d); check(d == 32'h3000_0000, "R11 ctrl1 mode bits", d, 32'h3000_0000);
      wr(A_C1, 32'h0);
      wr(A_TX, 32'hA5C3_5A3C); rd(A_TX, d); check(d == 32'hA5C3_5A3C, "R12 tx offset", d, 32'hA5C3_5A3C);
      wr(A_C2, 32'h0000_3073); rd(A_C2, d); check(d == 32'h3073, "R11 ctrl2 fields", d, 32'h3073);
      repeat (20) @(negedge clk);
      check(spi_cs_n == 4'hF && rise_cnt == 0, "R11 no trigger no transfer", spi_cs_n, 4'hF);

      // R3 four-byte command on bank 2
      wr(A_TX, 32'h5634_12D8); set_reply(4, 0, 0);
      xfer(32'h0000_2084, 2, 32, -5, A_ST, 0, "erase");
      check(mosi_q[31:0] == 32'hD812_3456, "R3 byte order", mosi_q[31:0], 32'hD812_3456);
      rd(A_RX, d); check(d == 0, "R4 no rx bytes", d, 0);
      rd(A_C2, d); check(d == 32'h2004, "R11 trigger reads 0", d, 32'h2004);
      rd(A_ST, d); check(d == 32'h100, "R9 flag set", d, 32'h100);
      wr(A_ST, 0);

      // R4 identification read on bank 0
      wr(A_TX, 32'h0000_009F); set_reply(1, 32'h0016_20C2, 3);
      xfer(32'h0000_00B1, 0, 32, -5, A_ST, 0, "id");
      check(mosi_q[31:0] == 32'h9FFF_FFFF, "R3 mosi high in rx", mosi_q[31:0], 32'h9FFF_FFFF);
      rd(A_RX, d); check(d == 32'h0016_20C2, "R4 rx packing", d, 32'h0016_20C2);
      wr(A_ST, 0);

      // R6 status read on bank 1
      set_reply(1, 32'h03, 1);
      xfer(32'h0000_1400, 1, 16, -5, A_ST, 0, "stsrd");
      check(mosi_q[15:0] == 16'h05FF, "R6 opcode", mosi_q[15:0], 16'h05FF);
      rd(A_ST, d); check(d == 32'h103, "R6 status byte", d, 32'h103);
      rd(A_RX, d); check(d == 32'h0016_20C2, "R6 rx untouched", d, 32'h0016_20C2);
      wr(A_ST, 0);

      // R7 write enable on bank 3
      slv_stream = '1;
      xfer(32'h0000_3800, 3, 8, -5, A_ST, 0, "wren");
      check(mosi_q[7:0] == 8'h06, "R7 opcode", mosi_q[7:0], 8'h06);
      rd(A_ST, d); check(d == 32'h103, "R7 status byte kept", d, 32'h103);
      rd(A_RX, d); check(d == 32'h0016_20C2, "R7 rx untouched", d, 32'h0016_20C2);
      wr(A_ST, 0);

      // R8 priority
      set_reply(1, 32'h02, 1);
      xfer(32'h0000_0C81, 0, 16, -5, A_ST, 0, "prio1");
      check(mosi_q[15:0] == 16'h05FF, "R8 status read wins", mosi_q[15:0], 16'h05FF);
      rd(A_ST, d); check(d == 32'h102, "R8 status byte", d, 32'h102);
      wr(A_ST, 0);
      xfer(32'h0000_0881, 0, 8, -5, A_ST, 0, "prio2");
      check(mosi_q[7:0] == 8'h06, "R8 write enable over send", mosi_q[7:0], 8'h06);
      rd(A_RX, d); check(d == 32'h0016_20C2, "R8 rx untouched", d, 32'h0016_20C2);
      wr(A_ST, 0);

      // R3 R4 count clamping
      wr(A_TX, 32'h89AB_CDEF); set_reply(4, 32'h4433_2211, 4);
      xfer(32'h0000_00F7, 0, 64, -5, A_ST, 0, "clamp");
      m = 64'hEFCD_AB89_FFFF_FFFF;
      check(mosi_q == m, "R3 clamp to four", mosi_q, m);
      rd(A_RX, d); check(d == 32'h4433_2211, "R4 clamp to four", d, 32'h4433_2211);
      wr(A_ST, 0);
      set_reply(1, 0, 0);
      xfer(32'h0000_0080, 0, 8, -5, A_ST, 0, "zerotx");
      check(mosi_q[7:0] == 8'hEF, "R3 zero means one", mosi_q[7:0], 8'hEF);
      rd(A_RX, d); check(d == 0, "R4 unreceived lanes zero", d, 0);
      wr(A_ST, 0);

      // R10 write while busy
      xfer(32'h0000_1800, 1, 8, 5, A_C2, 32'h0000_2084, "busy");
      rd(A_C2, d); check(d == 32'h1000, "R10 fields unchanged", d, 32'h1000);
      repeat (80) @(negedge clk);
      check(rise_cnt == 8 && spi_cs_n == 4'hF, "R10 no second transfer", rise_cnt, 8);

      // R9 write-one keeps, write-zero clears
      wr(A_ST, 32'h100); rd(A_ST, d); check(d == 32'h102, "R9 write one keeps", d, 32'h102);
      wr(A_ST, 32'hFFFF_FEFF); rd(A_ST, d); check(d == 32'h002, "R9 write zero clears", d, 32'h002);

      // R9 clear on the completion edge
      xfer(32'h0000_0800, 0, 8, 2 + (2*8 + 4)*HALF - 1, A_ST, 32'h0, "collide");
      rd(A_ST, d); check(d[8] == 1'b1, "R9 set wins", d[8], 1);

      finish_run();
   end
endmodule